// File: doc/BRIEF.md
# Per-Core Local Tick Timer Bank

This block holds a bank of identical local tick timers, one per core, each reached through its own 256-byte window on a simple 32-bit register bus. Each timer has two counting stages. A prescaler divides the input clock by its tick-count buffer value plus one. An interrupt counter then counts the resulting ticks down from a buffered reload value. When the interrupt counter expires, a sticky status flag is set. The flag drives that instance's interrupt line whenever the enable bit is set.

Software programs the buffers and then starts both stages through the control register. It can run a single expiry (one-shot) or repeat expiries indefinitely (interval mode). Writing the interrupt-count buffer with its top bit set also loads the value straight into the live counter. Every write to the tick buffer, the interrupt buffer or the control register raises a sticky acknowledge flag. Software polls this flag and clears it by writing 1.

The prescaler has two states, PS_IDLE and PS_RUN. It moves PS_IDLE→PS_RUN on a start (tick-run bit going 0→1) and PS_RUN→PS_IDLE when that bit is cleared. The interrupt counter has three states, IC_IDLE, IC_COUNT and IC_DONE. Its transitions are:
- IC_IDLE→IC_COUNT on a start (interrupt-run bit going 0→1).
- IC_COUNT→IC_DONE on expiry with interval mode off.
- IC_COUNT stays in IC_COUNT on expiry with interval mode on, reloading.
- IC_COUNT→IC_IDLE and IC_DONE→IC_IDLE when the run bit is cleared.

Top module: `lt_tick_bank`

## Requirements
- R1: Instance n decodes addresses 0x300+0x100*n. Its offsets are: tick buffer 0x00, interrupt buffer 0x08 (bits 30:0 read back, bit 31 reads 0), control 0x20, status 0x30, enable 0x34 and acknowledge 0x40. All registers read 0 after reset, and the interrupt lines are low after reset.
- R2: While control bit 0 is set, the prescaler issues one tick every (tick buffer + 1) clock cycles.
- R3: Expiry occurs on the tick that arrives while the live interrupt count is 0. After a control write that sets bits 0 and 1 together, status bit 0 becomes set exactly (I+1)*(T+1) cycles after that write's clock edge, where I is the interrupt buffer and T is the tick buffer.
- R4: With control bit 2 clear, the interrupt counter halts after its first expiry, and the status is not set again.
- R5: With control bit 2 set, the counter reloads from the interrupt buffer on expiry and expires again every (I+1)*(T+1) cycles.
- R6: A write to the interrupt buffer with bit 31 set loads bits 30:0 into the live counter on the same edge. Without bit 31, the running count is not affected.
- R7: Status bit 0 is cleared by writing 1 to it. The interrupt output equals status bit 0 AND enable bit 0.
- R8: Acknowledge bit 0, bit 1 and bit 3 are set by writes to the tick buffer, the interrupt buffer and the control register respectively. Each is cleared by writing 1 to that bit.
- R9: Clearing the run bits freezes both counters, so no expiry occurs. A later start reloads both counters from their buffers.
- R10: Instances are independent: programming and running one instance does not change another's registers or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW (12) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| irq | output | NUM_CH (2) | One interrupt line per instance |

## Verification
A wrong state transition or count value shows up as an interrupt edge that arrives early, late or not at all. The bench therefore measures the exact cycle distance from the start write to the interrupt, so an off-by-one in either stage shows within one timer period. A counter that fails to halt or to freeze raises a second interrupt within one period after the status is cleared. A misdecoded window or acknowledge bit shows on the very next read.

// File: rtl/lt_tick_pkg.sv
package lt_tick_pkg;

    localparam logic [7:0] OFS_TCNT  = 8'h00;
    localparam logic [7:0] OFS_ICNT  = 8'h08;
    localparam logic [7:0] OFS_CTRL  = 8'h20;
    localparam logic [7:0] OFS_ISTAT = 8'h30;
    localparam logic [7:0] OFS_IEN   = 8'h34;
    localparam logic [7:0] OFS_WSTAT = 8'h40;

    localparam int WIN_FIRST = 3;

    typedef enum logic [0:0] {
        PS_IDLE,
        PS_RUN
    } ps_state_e;

    typedef enum logic [1:0] {
        IC_IDLE,
        IC_COUNT,
        IC_DONE
    } ic_state_e;

    typedef struct packed {
        logic interval;
        logic icnt_run;
        logic tick_run;
    } ctrl_t;

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
    import lt_tick_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_d,
    input  logic          start,
    input  logic [PW-1:0] reload,
    output logic          tick_o
);

    ps_state_e     st_q, st_d;
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_IDLE: if (start)  st_d = PS_RUN;
            PS_RUN:  if (!run_d) st_d = PS_IDLE;
            default: st_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= reload;
        end else if (st_q == PS_RUN && run_d) begin
            if (cnt_q == '0) cnt_q <= reload;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        tick_o = (st_q == PS_RUN) && run_d && (cnt_q == '0);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && reload != '0) |=> !tick_o); // R2

endmodule

// File: rtl/lt_irq_counter.sv
module lt_irq_counter
    import lt_tick_pkg::*;
#(
    parameter int IW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_d,
    input  logic          start,
    input  logic          upd,
    input  logic [IW-1:0] upd_val,
    input  logic [IW-1:0] reload,
    input  logic          interval,
    input  logic          tick,
    output logic          expire_o
);

    ic_state_e     st_q, st_d;
    logic [IW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IC_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        expire_o = (st_q == IC_COUNT) && run_d && tick && (cnt_q == '0) && !upd;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IC_IDLE: if (start) st_d = IC_COUNT;
            IC_COUNT: begin
                if (!run_d)                     st_d = IC_IDLE;
                else if (expire_o && !interval) st_d = IC_DONE;
            end
            IC_DONE: if (!run_d) st_d = IC_IDLE;
            default: st_d = IC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (upd) begin
            cnt_q <= upd_val;
        end else if (start) begin
            cnt_q <= reload;
        end else if (st_q == IC_COUNT && run_d && tick) begin
            if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
            else if (interval) cnt_q <= reload;
        end
    end

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == IC_IDLE && !start && !upd) |=> $stable(cnt_q)); // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == IC_DONE && run_d && !upd) |=> (st_q == IC_DONE && $stable(cnt_q))); // R4
    AST_INTERVAL_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && interval) |=> (cnt_q == $past(reload) && st_q == IC_COUNT)); // R5

endmodule

// File: rtl/lt_channel.sv
module lt_channel
    import lt_tick_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 32,
    parameter int IW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [7:0]    ofs,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_o
);

    logic          wr_tcnt, wr_icnt, wr_ctrl, wr_istat, wr_ien, wr_wstat;
    logic [PW-1:0] tcntb_q;
    logic [IW-1:0] icntb_q;
    ctrl_t         ctrl_q, ctrl_d;
    logic          stat_q, en_q;
    logic [2:0]    ack_q;
    logic          tick_start, icnt_start, upd, tick, expire;

    always_comb begin
        wr_tcnt  = we && ofs == OFS_TCNT;
        wr_icnt  = we && ofs == OFS_ICNT;
        wr_ctrl  = we && ofs == OFS_CTRL;
        wr_istat = we && ofs == OFS_ISTAT;
        wr_ien   = we && ofs == OFS_IEN;
        wr_wstat = we && ofs == OFS_WSTAT;
        ctrl_d     = wr_ctrl ? ctrl_t'(wdata[2:0]) : ctrl_q;
        tick_start = ctrl_d.tick_run && !ctrl_q.tick_run;
        icnt_start = ctrl_d.icnt_run && !ctrl_q.icnt_run;
        upd        = wr_icnt && wdata[DW-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcntb_q <= '0;
            icntb_q <= '0;
            ctrl_q  <= '0;
            en_q    <= 1'b0;
        end else begin
            if (wr_tcnt) tcntb_q <= wdata[PW-1:0];
            if (wr_icnt) icntb_q <= wdata[IW-1:0];
            ctrl_q <= ctrl_d;
            if (wr_ien)  en_q <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (expire) begin
            stat_q <= 1'b1;
        end else if (wr_istat && wdata[0]) begin
            stat_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else begin
            if (wr_tcnt)                    ack_q[0] <= 1'b1;
            else if (wr_wstat && wdata[0])  ack_q[0] <= 1'b0;
            if (wr_icnt)                    ack_q[1] <= 1'b1;
            else if (wr_wstat && wdata[1])  ack_q[1] <= 1'b0;
            if (wr_ctrl)                    ack_q[2] <= 1'b1;
            else if (wr_wstat && wdata[3])  ack_q[2] <= 1'b0;
        end
    end

    lt_prescaler #(.PW(PW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_d  (ctrl_d.tick_run),
        .start  (tick_start),
        .reload (tcntb_q),
        .tick_o (tick)
    );

    lt_irq_counter #(.IW(IW)) u_icnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_d    (ctrl_d.icnt_run),
        .start    (icnt_start),
        .upd      (upd),
        .upd_val  (wdata[IW-1:0]),
        .reload   (icntb_q),
        .interval (ctrl_q.interval),
        .tick     (tick),
        .expire_o (expire)
    );

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_TCNT:  rdata = DW'(tcntb_q);
            OFS_ICNT:  rdata = DW'(icntb_q);
            OFS_CTRL:  rdata = DW'(ctrl_q);
            OFS_ISTAT: rdata = DW'(stat_q);
            OFS_IEN:   rdata = DW'(en_q);
            OFS_WSTAT: rdata = DW'({ack_q[2], 1'b0, ack_q[1], ack_q[0]});
            default:   rdata = '0;
        endcase
        irq_o = stat_q && en_q;
    end

    AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(expire)); // R7
    AST_ACK_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ack_q[2]); // R8
    AST_ACK_ICNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_icnt |=> ack_q[1]); // R8

endmodule

// File: rtl/lt_tick_bank.sv
module lt_tick_bank
    import lt_tick_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int AW     = 12,
    parameter int DW     = 32,
    parameter int PW     = 32,
    parameter int IW     = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int WSEL_W = AW - 8;

    logic [WSEL_W-1:0] win;
    logic [7:0]        ofs;
    logic [NUM_CH-1:0] sel;
    logic [DW-1:0]     ch_rd [NUM_CH];

    always_comb begin
        win = bus_addr[AW-1:8];
        ofs = bus_addr[7:0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [WSEL_W-1:0] MY_WIN = WSEL_W'(WIN_FIRST + g);

        assign sel[g] = (win == MY_WIN);

        lt_channel #(.DW(DW), .PW(PW), .IW(IW)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_we && sel[g]),
            .ofs   (ofs),
            .wdata (bus_wdata),
            .rdata (ch_rd[g]),
            .irq_o (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) bus_rdata = ch_rd[i];
        end
    end

    AST_IRQ_LOW_IN_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> irq == '0); // R1

endmodule

// File: tb/sim_lt_tick_bank.sv
module sim_lt_tick_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int wcyc = 0;
    int hit = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lt_tick_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [11:0] adr(input int ch, input logic [7:0] o);
        return 12'(12'h300 + ch * 12'h100 + o);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        wcyc = cyc;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int ch, input int limit);
        hit = -1;
        for (int k = 0; k < limit; k++) begin
            @(posedge clk);
            #1;
            if (irq[ch]) begin
                hit = cyc;
                break;
            end
        end
    endtask

    task automatic idle_quiet(input int ch, input int n, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            if (irq[ch]) seen = 1'b1;
        end
        check(!seen, req, seen, 0);
    endtask

    task automatic stop_clear(input int ch);
        wr(adr(ch, 8'h20), 32'h0);
        wr(adr(ch, 8'h30), 32'h1);
    endtask

    task automatic t_reset;
        rd(adr(0, 8'h00), rv); check(rv == 0, "R1 tick buffer reset", rv, 0);
        rd(adr(0, 8'h20), rv); check(rv == 0, "R1 control reset", rv, 0);
        rd(adr(1, 8'h40), rv); check(rv == 0, "R1 ack reset", rv, 0);
        check(irq == 2'b00, "R1 irq reset", irq, 0);
    endtask

    task automatic t_regs;
        wr(adr(0, 8'h00), 32'h0000_1234);
        rd(adr(0, 8'h00), rv); check(rv == 32'h1234, "R1 tick buffer readback", rv, 32'h1234);
        wr(adr(0, 8'h08), 32'h8000_0055);
        rd(adr(0, 8'h08), rv); check(rv == 32'h55, "R1 interrupt buffer readback", rv, 32'h55);
        wr(adr(0, 8'h20), 32'h4);
        rd(adr(0, 8'h20), rv); check(rv == 32'h4, "R1 control readback", rv, 4);
        wr(adr(0, 8'h20), 32'h0);
    endtask

    task automatic t_ack;
        rd(adr(0, 8'h40), rv); check(rv == 32'hB, "R8 ack bits set", rv, 32'hB);
        wr(adr(0, 8'h40), 32'h2);
        rd(adr(0, 8'h40), rv); check(rv == 32'h9, "R8 ack bit1 cleared alone", rv, 32'h9);
        wr(adr(0, 8'h40), 32'h9);
        rd(adr(0, 8'h40), rv); check(rv == 32'h0, "R8 ack cleared", rv, 0);
    endtask

    task automatic t_oneshot(input int t, input int i);
        int n = (i + 1) * (t + 1);
        wr(adr(0, 8'h00), 32'(t));
        wr(adr(0, 8'h08), 32'(i));
        wr(adr(0, 8'h34), 32'h1);
        wr(adr(0, 8'h20), 32'h3);
        wait_irq(0, 4 * n + 10);
        check(hit - wcyc == n, "R2 R3 expiry delay", hit - wcyc, n);
        rd(adr(0, 8'h30), rv); check(rv == 1, "R3 status set", rv, 1);
        wr(adr(0, 8'h30), 32'h1);
        check(irq[0] == 1'b0, "R7 status cleared by W1C", irq[0], 0);
        idle_quiet(0, 3 * n + 5, "R4 one-shot halts");
        stop_clear(0);
    endtask

    task automatic t_interval;
        int a;
        wr(adr(0, 8'h00), 32'd1);
        wr(adr(0, 8'h08), 32'd5);
        wr(adr(0, 8'h20), 32'h7);
        wait_irq(0, 100);
        check(hit - wcyc == 12, "R5 first interval expiry", hit - wcyc, 12);
        a = hit;
        wr(adr(0, 8'h30), 32'h1);
        wait_irq(0, 100);
        check(hit - a == 12, "R5 repeated expiry", hit - a, 12);
        stop_clear(0);
    endtask

    task automatic t_enable;
        wr(adr(0, 8'h34), 32'h0);
        wr(adr(0, 8'h00), 32'd0);
        wr(adr(0, 8'h08), 32'd3);
        wr(adr(0, 8'h20), 32'h3);
        idle_quiet(0, 10, "R7 irq gated by enable");
        rd(adr(0, 8'h30), rv); check(rv == 1, "R7 status set while disabled", rv, 1);
        wr(adr(0, 8'h34), 32'h1);
        check(irq[0] == 1'b1, "R7 irq follows enable", irq[0], 1);
        stop_clear(0);
    endtask

    task automatic t_update;
        int w;
        wr(adr(0, 8'h00), 32'd0);
        wr(adr(0, 8'h08), 32'd100);
        wr(adr(0, 8'h20), 32'h3);
        repeat (4) @(posedge clk);
        wr(adr(0, 8'h08), 32'h8000_0002);
        wait_irq(0, 200);
        check(hit - wcyc == 3, "R6 update bit loads live count", hit - wcyc, 3);
        stop_clear(0);
        wr(adr(0, 8'h08), 32'd20);
        wr(adr(0, 8'h20), 32'h3);
        w = wcyc;
        repeat (4) @(posedge clk);
        wr(adr(0, 8'h08), 32'd5);
        wait_irq(0, 100);
        check(hit - w == 21, "R6 buffer write without update bit", hit - w, 21);
        stop_clear(0);
    endtask

    task automatic t_freeze;
        wr(adr(0, 8'h00), 32'd0);
        wr(adr(0, 8'h08), 32'd10);
        wr(adr(0, 8'h20), 32'h3);
        repeat (3) @(posedge clk);
        wr(adr(0, 8'h20), 32'h0);
        idle_quiet(0, 30, "R9 stopped counter frozen");
        wr(adr(0, 8'h20), 32'h3);
        wait_irq(0, 100);
        check(hit - wcyc == 11, "R9 restart reloads", hit - wcyc, 11);
        stop_clear(0);
    endtask

    task automatic t_indep;
        wr(adr(0, 8'h08), 32'd77);
        wr(adr(1, 8'h00), 32'd0);
        wr(adr(1, 8'h08), 32'd6);
        wr(adr(1, 8'h34), 32'h1);
        wr(adr(1, 8'h20), 32'h3);
        wait_irq(1, 50);
        check(hit - wcyc == 7, "R10 second instance expiry", hit - wcyc, 7);
        check(irq[0] == 1'b0, "R10 first instance quiet", irq[0], 0);
        rd(adr(0, 8'h08), rv); check(rv == 77, "R10 first instance buffer kept", rv, 77);
        rd(adr(0, 8'h20), rv); check(rv == 0, "R10 first instance control kept", rv, 0);
        stop_clear(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_regs;
        t_ack;
        t_oneshot(3, 4);
        t_oneshot(0, 7);
        t_interval;
        t_enable;
        t_update;
        t_freeze;
        t_indep;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule